// File: doc/BRIEF.md
# SMBus Host Controller Register Block

This block is the byte-wide register file a processor uses to set up and start SMBus transactions. The processor writes a target address with a direction flag, a command byte, up to two data bytes and an optional block payload, then writes the control register with its start bit set. The block turns those register contents into one abstract transaction request for a responder. When the responder finishes, the block stores the data it returned or raises an error flag.

A single block-data register gives access to a 32-byte buffer. Each access uses the current buffer index and then advances it, and the index wraps after the last entry. Two side effects return the index to the first entry: writing the status register and reading the control register. The request uses a valid/done handshake. While a request is outstanding, register writes are still accepted, but a second start has no effect.

Top module: `smb_host_regs`

## Requirements
- R1: The register offsets are fixed: 0x00 status, 0x02 control, 0x03 command, 0x04 target, 0x05 data-low, 0x06 data-high, 0x07 block data. Reads of command, target, data-low and data-high return the last value stored.
- R2: A read of any other offset returns 0x00. A write to any other offset changes no register.
- R3: Writing any value to status clears every status bit and sets the block index to entry 0.
- R4: A control write with bit 6 set issues one request. Its protocol is the written bits [4:2], its 7-bit target is target register bits [7:1], and its direction is target bit 0 (1 = read). It also carries the command, data-low and data-high registers and the buffer contents.
- R5: Protocol codes 0 (quick), 1 (single byte), 2 (byte with command), 3 (word) and 5 (block) are accepted. A start with code 4, 6 or 7 issues no request and sets status bit 2 (0x04).
- R6: A request that the responder reports as failed sets status bit 2. Absent targets and unsupported protocols are reported this way.
- R7: A completed read with protocol 1 or 2 loads the returned byte into data-low. Writes and quick commands leave data-low and data-high unchanged.
- R8: A word write presents {data-high, data-low}. A completed word read loads the low result byte into data-low and the high result byte into data-high.
- R9: A block write presents data-low as the byte count, with the buffer as payload. A completed block read stores the returned count in data-low and the returned bytes in the buffer.
- R10: Each block-data read or write uses the entry at the current index and then increments the index. The index wraps from entry 31 to entry 0.
- R11: A control read returns the stored bits [4:0] with bits [7:5] as zero, and sets the block index to entry 0. A control write without bit 6 only stores the value.
- R12: The request valid stays high with stable fields until the responder's done pulse. A start written while a request is outstanding is ignored, but the register writes themselves take effect.
- R13: After reset, every register reads 0x00, the block index is 0 and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 6 | Register offset |
| cpu_wr | input | 1 | Write strobe, one cycle per access |
| cpu_rd | input | 1 | Read strobe, one cycle per access; ignored when cpu_wr is high |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid in the cycle cpu_rd is high |
| req_valid | output | 1 | Request outstanding |
| req_proto | output | 3 | Protocol code of the request |
| req_target | output | 7 | 7-bit target address |
| req_read | output | 1 | 1 = read, 0 = write |
| req_cmd | output | 8 | Command byte |
| req_data0 | output | 8 | Data-low byte, or the block byte count |
| req_data1 | output | 8 | Data-high byte |
| req_block | output | 256 | Buffer contents, entry i in bits [8i+7:8i] |
| rsp_done | input | 1 | One-cycle completion pulse from the responder |
| rsp_fail | input | 1 | Failure flag, qualified by rsp_done |
| rsp_lo | input | 8 | Returned byte, low word byte, or block count |
| rsp_hi | input | 8 | High word byte returned |
| rsp_block | input | 256 | Returned block bytes, same layout as req_block |

## Verification
The assertions assume a well-behaved CPU and responder. Each CPU access lasts one cycle, and the responder raises rsp_done only while req_valid is high, as a single-cycle pulse. The assertions also assume that the block buffer is not written through the CPU port while a block request is outstanding. The bench drives every access for exactly one cycle from tasks. Its responder model counts cycles of req_valid and then pulses done once. Block-data writes happen only between transactions; in the overlap test, only the command and control registers are written during a pending request.

// File: rtl/smbh_pkg.sv
package smbh_pkg;

  localparam logic [5:0] OFF_STAT = 6'h00;
  localparam logic [5:0] OFF_CTL  = 6'h02;
  localparam logic [5:0] OFF_CMD  = 6'h03;
  localparam logic [5:0] OFF_TGT  = 6'h04;
  localparam logic [5:0] OFF_D0   = 6'h05;
  localparam logic [5:0] OFF_D1   = 6'h06;
  localparam logic [5:0] OFF_BLK  = 6'h07;

  localparam logic [2:0] PR_QUICK = 3'd0;
  localparam logic [2:0] PR_BYTE  = 3'd1;
  localparam logic [2:0] PR_BDATA = 3'd2;
  localparam logic [2:0] PR_WORD  = 3'd3;
  localparam logic [2:0] PR_BLOCK = 3'd5;

  localparam int START_BIT = 6;
  localparam int FAIL_BIT  = 2;

  function automatic logic proto_ok(input logic [2:0] p);
    return (p == PR_QUICK) || (p == PR_BYTE) || (p == PR_BDATA) ||
           (p == PR_WORD) || (p == PR_BLOCK);
  endfunction

  function automatic logic off_mapped(input logic [5:0] o);
    return (o == OFF_STAT) || (o == OFF_CTL) || (o == OFF_CMD) || (o == OFF_TGT) ||
           (o == OFF_D0) || (o == OFF_D1) || (o == OFF_BLK);
  endfunction

  // Read completion of these protocols returns a byte into data-low.
  function automatic logic loads_low(input logic [2:0] p, input logic rd);
    return rd && ((p == PR_BYTE) || (p == PR_BDATA) || (p == PR_WORD) || (p == PR_BLOCK));
  endfunction

  function automatic logic loads_high(input logic [2:0] p, input logic rd);
    return rd && (p == PR_WORD);
  endfunction

  function automatic int unsigned wrap_inc(input int unsigned i, input int unsigned depth);
    return (i + 1 >= depth) ? 0 : i + 1;
  endfunction

endpackage

// File: rtl/smbh_blkbuf.sv
module smbh_blkbuf #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                idx_clr,
  input  logic                acc,
  input  logic                wr_en,
  input  logic [DW-1:0]       wr_byte,
  input  logic                bulk_we,
  input  logic [DEPTH*DW-1:0] bulk_in,
  output logic [DW-1:0]       rd_byte,
  output logic [DEPTH*DW-1:0] flat_out,
  output logic [IW-1:0]       idx
);

  logic [DW-1:0] mem_q [DEPTH];
  logic [IW-1:0] idx_q;
  logic [IW-1:0] idx_nx;

  assign idx_nx  = IW'(smbh_pkg::wrap_inc(32'(idx_q), DEPTH));
  assign rd_byte = mem_q[idx_q];
  assign idx     = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx_q <= '0;
    else if (idx_clr) idx_q <= '0;
    else if (acc)     idx_q <= idx_nx;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               mem_q[g] <= '0;
      else if (bulk_we)                         mem_q[g] <= bulk_in[g*DW +: DW];
      else if (wr_en && (idx_q == IW'(g)))      mem_q[g] <= wr_byte;
    end
    assign flat_out[g*DW +: DW] = mem_q[g];
  end

  // R10: one access moves the index by exactly one entry, wrapping at the end
  a_r10_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !idx_clr) |=> (($past(idx_q) == IW'(DEPTH-1)) ? (idx_q == '0)
                                                           : (idx_q == $past(idx_q) + 1'b1)));

  // R3, R11: a clearing side effect returns the index to entry 0
  a_r3_idx_clear: assert property (@(posedge clk) disable iff (!rst_n)
    idx_clr |=> (idx_q == '0));

endmodule

// File: rtl/smbh_launch.sv
module smbh_launch #(
  parameter int DW = 8,
  localparam int AW = DW - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    proto_in,
  input  logic [DW-1:0] tgt_in,
  input  logic [DW-1:0] cmd_in,
  input  logic [DW-1:0] d0_in,
  input  logic [DW-1:0] d1_in,
  input  logic          rsp_done,
  input  logic          rsp_fail,
  output logic          req_valid,
  output logic [2:0]    req_proto,
  output logic [AW-1:0] req_target,
  output logic          req_read,
  output logic [DW-1:0] req_cmd,
  output logic [DW-1:0] req_data0,
  output logic [DW-1:0] req_data1,
  output logic          fin_ok,
  output logic          err_set
);

  logic fire, bad_code, go;

  assign fire     = start && !req_valid;
  assign bad_code = fire && !smbh_pkg::proto_ok(proto_in);
  assign go       = fire && smbh_pkg::proto_ok(proto_in);
  assign fin_ok   = req_valid && rsp_done && !rsp_fail;
  assign err_set  = bad_code || (req_valid && rsp_done && rsp_fail);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid  <= 1'b0;
      req_proto  <= '0;
      req_target <= '0;
      req_read   <= 1'b0;
      req_cmd    <= '0;
      req_data0  <= '0;
      req_data1  <= '0;
    end else if (go) begin
      req_valid  <= 1'b1;
      req_proto  <= proto_in;
      req_target <= tgt_in[DW-1:1];
      req_read   <= tgt_in[0];
      req_cmd    <= cmd_in;
      req_data0  <= d0_in;
      req_data1  <= d1_in;
    end else if (req_valid && rsp_done) begin
      req_valid  <= 1'b0;
    end
  end

  // R12: the request stays up until done
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !rsp_done) |=> req_valid);

  // R12: fields do not move while outstanding, even if a new start is written
  a_r12_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !rsp_done) |=> ($stable(req_proto) && $stable(req_target) &&
                                  $stable(req_read) && $stable(req_cmd) &&
                                  $stable(req_data0) && $stable(req_data1)));

  // R5: an unsupported code never reaches the request port
  a_r5_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> smbh_pkg::proto_ok(req_proto));

  // R4: an idle start with a legal code raises valid on the next cycle
  a_r4_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !req_valid && smbh_pkg::proto_ok(proto_in)) |=> (req_valid && req_proto == $past(proto_in)));

endmodule

// File: rtl/smb_host_regs.sv
module smb_host_regs #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  parameter int OFFW  = 6,
  localparam int AW   = DW - 1,
  localparam int BW   = DEPTH * DW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OFFW-1:0] cpu_addr,
  input  logic            cpu_wr,
  input  logic            cpu_rd,
  input  logic [DW-1:0]   cpu_wdata,
  output logic [DW-1:0]   cpu_rdata,
  output logic            req_valid,
  output logic [2:0]      req_proto,
  output logic [AW-1:0]   req_target,
  output logic            req_read,
  output logic [DW-1:0]   req_cmd,
  output logic [DW-1:0]   req_data0,
  output logic [DW-1:0]   req_data1,
  output logic [BW-1:0]   req_block,
  input  logic            rsp_done,
  input  logic            rsp_fail,
  input  logic [DW-1:0]   rsp_lo,
  input  logic [DW-1:0]   rsp_hi,
  input  logic [BW-1:0]   rsp_block
);
  import smbh_pkg::*;

  localparam int IW = $clog2(DEPTH);

  logic [DW-1:0] stat_q, cmd_q, tgt_q, d0_q, d1_q;
  logic [4:0]    ctl_q;

  logic wr, rd;
  logic [5:0] off;
  logic hit_stat, hit_ctl, hit_cmd, hit_tgt, hit_d0, hit_d1, hit_blk;
  logic start, fin_ok, err_set, idx_clr, blk_acc, bulk_we;
  logic ld_low, ld_high;
  logic [DW-1:0] blk_byte;
  logic [IW-1:0] blk_idx;

  assign off = 6'(cpu_addr);
  assign wr  = cpu_wr;
  assign rd  = cpu_rd && !cpu_wr;

  assign hit_stat = (off == OFF_STAT);
  assign hit_ctl  = (off == OFF_CTL);
  assign hit_cmd  = (off == OFF_CMD);
  assign hit_tgt  = (off == OFF_TGT);
  assign hit_d0   = (off == OFF_D0);
  assign hit_d1   = (off == OFF_D1);
  assign hit_blk  = (off == OFF_BLK);

  assign start   = wr && hit_ctl && cpu_wdata[START_BIT];
  assign idx_clr = (wr && hit_stat) || (rd && hit_ctl);
  assign blk_acc = (wr || rd) && hit_blk;
  assign ld_low  = fin_ok && loads_low(req_proto, req_read);
  assign ld_high = fin_ok && loads_high(req_proto, req_read);
  assign bulk_we = fin_ok && req_read && (req_proto == PR_BLOCK);

  smbh_launch #(.DW(DW)) u_launch (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .proto_in  (cpu_wdata[4:2]),
    .tgt_in    (tgt_q),
    .cmd_in    (cmd_q),
    .d0_in     (d0_q),
    .d1_in     (d1_q),
    .rsp_done  (rsp_done),
    .rsp_fail  (rsp_fail),
    .req_valid (req_valid),
    .req_proto (req_proto),
    .req_target(req_target),
    .req_read  (req_read),
    .req_cmd   (req_cmd),
    .req_data0 (req_data0),
    .req_data1 (req_data1),
    .fin_ok    (fin_ok),
    .err_set   (err_set)
  );

  smbh_blkbuf #(.DEPTH(DEPTH), .DW(DW)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .idx_clr (idx_clr),
    .acc     (blk_acc),
    .wr_en   (wr && hit_blk),
    .wr_byte (cpu_wdata),
    .bulk_we (bulk_we),
    .bulk_in (rsp_block),
    .rd_byte (blk_byte),
    .flat_out(req_block),
    .idx     (blk_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      ctl_q  <= '0;
      cmd_q  <= '0;
      tgt_q  <= '0;
      d0_q   <= '0;
      d1_q   <= '0;
    end else begin
      if (wr && hit_stat) stat_q <= '0;
      if (err_set)        stat_q[FAIL_BIT] <= 1'b1;
      if (wr && hit_ctl)  ctl_q <= cpu_wdata[4:0];
      if (wr && hit_cmd)  cmd_q <= cpu_wdata;
      if (wr && hit_tgt)  tgt_q <= cpu_wdata;
      if (ld_low)               d0_q <= rsp_lo;
      else if (wr && hit_d0)    d0_q <= cpu_wdata;
      if (ld_high)              d1_q <= rsp_hi;
      else if (wr && hit_d1)    d1_q <= cpu_wdata;
    end
  end

  always_comb begin
    cpu_rdata = '0;
    if (rd) begin
      unique case (1'b1)
        hit_stat: cpu_rdata = stat_q;
        hit_ctl:  cpu_rdata = DW'(ctl_q);
        hit_cmd:  cpu_rdata = cmd_q;
        hit_tgt:  cpu_rdata = tgt_q;
        hit_d0:   cpu_rdata = d0_q;
        hit_d1:   cpu_rdata = d1_q;
        hit_blk:  cpu_rdata = blk_byte;
        default:  cpu_rdata = '0;
      endcase
    end
  end

  // R5, R6: every error event leaves the fail flag set
  a_r6_fail_flag: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |=> stat_q[FAIL_BIT]);

  // R3: a status write with no concurrent error empties status
  a_r3_stat_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit_stat && !err_set) |=> (stat_q == '0));

  // R2: unmapped reads return zero
  a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !off_mapped(off)) |-> (cpu_rdata == '0));

  // R11: control readback never shows bits 7:5
  a_r11_ctl_view: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && hit_ctl) |-> (cpu_rdata[7:5] == 3'b000));

  // R8: a finished word read lands both result bytes
  a_r8_word_load: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_ok && req_read && req_proto == PR_WORD) |=> (d0_q == $past(rsp_lo) && d1_q == $past(rsp_hi)));

  // R9: a finished block read fills the buffer seen at the request port
  a_r9_block_fill: assert property (@(posedge clk) disable iff (!rst_n)
    bulk_we |=> (req_block == $past(rsp_block) && blk_idx == $past(blk_idx)));

endmodule

// File: tb/smb_host_regs_test.sv
module smb_host_regs_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [5:0]   cpu_addr = '0;
  logic         cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [7:0]   cpu_wdata = '0;
  logic [7:0]   cpu_rdata;
  logic         req_valid, req_read;
  logic [2:0]   req_proto;
  logic [6:0]   req_target;
  logic [7:0]   req_cmd, req_data0, req_data1;
  logic [255:0] req_block;
  logic         rsp_done, rsp_fail;
  logic [7:0]   rsp_lo, rsp_hi;
  logic [255:0] rsp_block;

  smb_host_regs uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .req_valid(req_valid),
    .req_proto(req_proto), .req_target(req_target), .req_read(req_read),
    .req_cmd(req_cmd), .req_data0(req_data0), .req_data1(req_data1),
    .req_block(req_block), .rsp_done(rsp_done), .rsp_fail(rsp_fail),
    .rsp_lo(rsp_lo), .rsp_hi(rsp_hi), .rsp_block(rsp_block)
  );

  int tests = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] mon_e;
  string      mon_t;

  always @(negedge clk) begin
    #1;
    if (cpu_rd) begin
      if (exp_q.size() == 0) chk("scoreboard underflow", 1, 0);
      else begin
        mon_e = exp_q.pop_front();
        mon_t = tag_q.pop_front();
        chk(mon_t, {24'h0, cpu_rdata}, {24'h0, mon_e});
      end
    end
  end

  task automatic wreg(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic rreg(input logic [5:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    cpu_rd = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
    while (req_valid) @(negedge clk);
    @(negedge clk);
  endtask

  // responder model: target 0x50 supports everything, 0x51 only quick
  logic [7:0] mem [256];
  logic [7:0] ptr = '0;
  int lat = 3, wcnt = 0, seen_cnt = 0;
  logic [2:0] seen_proto;
  logic [6:0] seen_tgt;
  logic seen_read;
  logic [7:0] seen_cmd, seen_d0, seen_d1;
  logic [255:0] seen_blk;

  task automatic respond();
    logic ok;
    seen_cnt++;
    seen_proto = req_proto; seen_tgt = req_target; seen_read = req_read;
    seen_cmd = req_cmd; seen_d0 = req_data0; seen_d1 = req_data1; seen_blk = req_block;
    ok = (req_target == 7'h50 && req_proto != 3'd4 && req_proto < 3'd6) ||
         (req_target == 7'h51 && req_proto == 3'd0);
    rsp_fail = !ok;
    if (ok && req_target == 7'h50) begin
      case (req_proto)
        3'd1: if (req_read) begin rsp_lo = mem[ptr]; ptr = ptr + 8'd1; end
              else ptr = req_cmd;
        3'd2: if (req_read) rsp_lo = mem[req_cmd]; else mem[req_cmd] = req_data0;
        3'd3: if (req_read) begin rsp_lo = mem[req_cmd]; rsp_hi = mem[8'(req_cmd + 8'd1)]; end
              else begin mem[req_cmd] = req_data0; mem[8'(req_cmd + 8'd1)] = req_data1; end
        3'd5: if (req_read) begin
                rsp_lo = 8'd6;
                for (int i = 0; i < 32; i++) rsp_block[i*8 +: 8] = mem[8'(req_cmd + 8'(i))];
              end else begin
                for (int i = 0; i < 32; i++)
                  if (i < int'(req_data0)) mem[8'(req_cmd + 8'(i))] = req_block[i*8 +: 8];
              end
        default: ;
      endcase
    end
  endtask

  initial begin
    rsp_done = 0; rsp_fail = 0; rsp_lo = 0; rsp_hi = 0; rsp_block = '0;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    forever begin
      @(negedge clk);
      rsp_done = 0; rsp_fail = 0;
      if (req_valid) begin
        wcnt++;
        if (wcnt >= lat) begin
          wcnt = 0;
          respond();
          rsp_done = 1;
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R13 reset state
    chk("R13 no request after reset", {31'h0, req_valid}, 0);
    rreg(6'h00, 8'h00, "R13 status reset");
    rreg(6'h02, 8'h00, "R13 control reset");
    rreg(6'h03, 8'h00, "R13 command reset");
    rreg(6'h05, 8'h00, "R13 data-low reset");
    rreg(6'h07, 8'h00, "R13 block entry reset");

    // R1 register storage, R2 unmapped
    wreg(6'h03, 8'hA5); wreg(6'h04, 8'h3C); wreg(6'h05, 8'h11); wreg(6'h06, 8'h22);
    rreg(6'h03, 8'hA5, "R1 command readback");
    rreg(6'h04, 8'h3C, "R1 target readback");
    rreg(6'h05, 8'h11, "R1 data-low readback");
    rreg(6'h06, 8'h22, "R1 data-high readback");
    wreg(6'h01, 8'hFF); wreg(6'h08, 8'hFF); wreg(6'h3F, 8'hFF);
    rreg(6'h01, 8'h00, "R2 unmapped 0x01 reads zero");
    rreg(6'h3F, 8'h00, "R2 unmapped 0x3F reads zero");
    rreg(6'h03, 8'hA5, "R2 command untouched by unmapped writes");
    rreg(6'h06, 8'h22, "R2 data-high untouched by unmapped writes");

    // R4 quick command to 0x50
    wreg(6'h04, 8'hA0);
    n0 = seen_cnt;
    wreg(6'h02, 8'h40); settle();
    chk("R4 one request issued", seen_cnt, n0 + 1);
    chk("R4 quick protocol", {29'h0, seen_proto}, 0);
    chk("R4 target field", {25'h0, seen_tgt}, 32'h50);
    chk("R4 write direction", {31'h0, seen_read}, 0);
    rreg(6'h00, 8'h00, "R4 quick ok, status clean");
    rreg(6'h05, 8'h11, "R7 quick leaves data-low");

    // R7 byte-data write then read
    wreg(6'h03, 8'h10); wreg(6'h05, 8'h77); wreg(6'h02, 8'h48); settle();
    chk("R4 byte-data write command", {24'h0, seen_cmd}, 32'h10);
    chk("R4 byte-data write data", {24'h0, seen_d0}, 32'h77);
    rreg(6'h05, 8'h77, "R7 write leaves data-low");
    wreg(6'h05, 8'h00); wreg(6'h04, 8'hA1); wreg(6'h02, 8'h48); settle();
    chk("R4 read direction", {31'h0, seen_read}, 1);
    rreg(6'h05, 8'h77, "R7 byte-data read result");

    // R7 send then receive byte
    wreg(6'h04, 8'hA0); wreg(6'h03, 8'h20); wreg(6'h02, 8'h44); settle();
    wreg(6'h04, 8'hA1); wreg(6'h02, 8'h44); settle();
    rreg(6'h05, 8'h7A, "R7 receive byte first");
    wreg(6'h02, 8'h44); settle();
    rreg(6'h05, 8'h7B, "R7 receive byte second");

    // R8 word write / read
    wreg(6'h04, 8'hA0); wreg(6'h03, 8'h30); wreg(6'h05, 8'h34); wreg(6'h06, 8'h12);
    wreg(6'h02, 8'h4C); settle();
    chk("R8 word write low", {24'h0, seen_d0}, 32'h34);
    chk("R8 word write high", {24'h0, seen_d1}, 32'h12);
    wreg(6'h05, 8'h00); wreg(6'h06, 8'h00); wreg(6'h04, 8'hA1); wreg(6'h02, 8'h4C); settle();
    rreg(6'h05, 8'h34, "R8 word read low to data-low");
    rreg(6'h06, 8'h12, "R8 word read high to data-high");

    // R9 block write
    wreg(6'h00, 8'h00);
    for (int i = 0; i < 4; i++) wreg(6'h07, 8'hC0 + 8'(i));
    wreg(6'h05, 8'h04); wreg(6'h03, 8'h40); wreg(6'h04, 8'hA0); wreg(6'h02, 8'h54); settle();
    chk("R9 block write count", {24'h0, seen_d0}, 4);
    chk("R9 block write payload", seen_blk[31:0], 32'hC3C2C1C0);
    chk("R9 block protocol", {29'h0, seen_proto}, 5);

    // R9 block read, R10 wrap, R11 control read
    wreg(6'h04, 8'hA1); wreg(6'h02, 8'h54); settle();
    rreg(6'h05, 8'h06, "R9 block read count");
    rreg(6'h02, 8'h14, "R11 control view bits 4:0");
    for (int i = 0; i < 32; i++)
      rreg(6'h07, (i < 4) ? (8'hC0 + 8'(i)) : (8'(8'h40 + 8'(i)) ^ 8'h5A), "R9 R10 block entry");
    rreg(6'h07, 8'hC0, "R10 index wraps after 31");
    rreg(6'h07, 8'hC1, "R10 increment after wrap");
    wreg(6'h00, 8'h5A);
    rreg(6'h07, 8'hC0, "R3 status write resets index");
    rreg(6'h07, 8'hC1, "R10 block read advance");
    rreg(6'h02, 8'h14, "R11 control read");
    rreg(6'h07, 8'hC0, "R11 control read resets index");

    // R10 writes also advance
    wreg(6'h00, 8'h00); wreg(6'h07, 8'hD0); wreg(6'h07, 8'hD1);
    wreg(6'h00, 8'h00);
    rreg(6'h07, 8'hD0, "R10 write stored at entry 0");
    rreg(6'h07, 8'hD1, "R10 write stored at entry 1");

    // R5 unsupported protocol
    n0 = seen_cnt;
    wreg(6'h02, 8'h50); settle();
    rreg(6'h00, 8'h04, "R5 bad code sets fail bit");
    chk("R5 bad code issues no request", seen_cnt, n0);
    wreg(6'h02, 8'h5C); settle();
    chk("R5 code 7 issues no request", seen_cnt, n0);
    wreg(6'h00, 8'h00);
    rreg(6'h00, 8'h00, "R3 status write clears");

    // R6 responder failures
    wreg(6'h04, 8'hA4); wreg(6'h02, 8'h48); settle();
    rreg(6'h00, 8'h04, "R6 absent target fails");
    wreg(6'h00, 8'h00);
    wreg(6'h04, 8'hA2); wreg(6'h02, 8'h48); settle();
    rreg(6'h00, 8'h04, "R6 unsupported protocol fails");
    wreg(6'h00, 8'h00);
    wreg(6'h02, 8'h40); settle();
    rreg(6'h00, 8'h00, "R6 supported quick at 0x51 ok");

    // R12 start while pending
    lat = 8;
    wreg(6'h04, 8'hA1); wreg(6'h03, 8'h10); wreg(6'h05, 8'h00);
    n0 = seen_cnt;
    wreg(6'h02, 8'h48);
    chk("R12 request pending", {31'h0, req_valid}, 1);
    wreg(6'h03, 8'h99);
    wreg(6'h02, 8'h4C);
    settle();
    chk("R12 only one request", seen_cnt, n0 + 1);
    chk("R12 snapshot command", {24'h0, seen_cmd}, 32'h10);
    chk("R12 snapshot protocol", {29'h0, seen_proto}, 2);
    rreg(6'h05, 8'h77, "R12 pending result lands");
    rreg(6'h03, 8'h99, "R12 write during pending accepted");
    lat = 3;

    // R11 control write without start
    n0 = seen_cnt;
    wreg(6'h02, 8'h9F); settle();
    rreg(6'h02, 8'h1F, "R11 control upper bits hidden");
    chk("R11 no start without bit 6", seen_cnt, n0);
    rreg(6'h00, 8'h00, "R11 no error without start");

    repeat (3) @(negedge clk);
    chk("scoreboard drained", exp_q.size(), 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule